// File: doc/BRIEF.md
# E1 CRC-4 E-Bit Transmit Controller

This block sets the two E bits in the transmit E1 CRC-4 multiframe. These bits sit in bit 1 of frame 13 and frame 15. A transmit frame counter gives the block a one-cycle `frame_tick` and the multiframe position `mf_pos` (0 to 15) of the frame that is starting. When the position is an E-bit slot, the block registers the bit value and raises a strobe for one cycle. The framer inserts the value into the outgoing frame.

Each bit is the logical AND of several sources, so any request for a 0 wins. The first source is a pair of configuration bits. In direct mode these bits are copied to the line. In one-shot mode, each write of 0 queues a single 0 bit. The second source is automatic remote error reporting: every errored CRC-4 submultiframe reported by the receiver queues one 0. The remaining sources force both bits to 0 during loss of CRC-4 multiframe alignment, either at once or only after the receive timer has expired. Queued zeros are held in a saturating counter for each slot, so bursts of events are not lost.

Top module: `ebit_tx_ctrl`

## Requirements
- R1: One cycle after a cycle with `frame_tick`=1 and `mf_pos`=13 (or 15), `e_stb` is 1 for one cycle and `e_sel` is 0 (or 1). Any other position gives no strobe.
- R2: With `cfg_oneshot`=0 and no other request, the frame-13 bit equals `cfg_e13_bit` and the frame-15 bit equals `cfg_e15_bit`.
- R3: With `cfg_oneshot`=1, each pulse of `cfg_e13_wr` (`cfg_e15_wr`) with data 0 queues exactly one 0 for a later frame-13 (frame-15) slot. Writes with data 1 are ignored. The held bit values have no direct effect in this mode.
- R4: With `cfg_auto_err_en`=1, each `rx_crc_err` pulse queues one 0 bit. When `rx_crc_smf`=0 the bit goes to frame 13, and when it is 1 the bit goes to frame 15. With the enable at 0, the pulse is ignored.
- R5: With `cfg_loss_zero_en`=1 and `rx_mf_loss`=1, both E bits are 0.
- R6: With `cfg_timer_zero_en`=1, both E bits are 0 while `rx_mf_loss`=1 and `rx_timer_exp`=1. `rx_timer_exp` has no effect while `rx_mf_loss`=0.
- R7: When no source asks for 0, the bit is 1. After reset `e_stb`=0, `e_val`=1 and no zeros are queued.
- R8: Each slot queues at most 2^`CNT_W`-1 zeros (7 by default), and further requests are dropped. A request that arrives in the same cycle as that slot's tick is served at a later slot.
- R9: Loss of basic frame alignment (`rx_fa_loss`) is treated as loss of multiframe alignment. `rx_fa_loss`=1 with `rx_mf_loss`=0 is an illegal input.
- R10: Any 0 sent in a slot with queued zeros retires one queued zero, even when the 0 was also forced by loss of alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | Start of a transmit frame |
| mf_pos | input | POS_W | Frame number within the multiframe |
| cfg_oneshot | input | 1 | 0 = direct mode, 1 = one-shot mode |
| cfg_e13_bit | input | 1 | Frame-13 control bit |
| cfg_e15_bit | input | 1 | Frame-15 control bit |
| cfg_e13_wr | input | 1 | Write strobe for the frame-13 bit |
| cfg_e15_wr | input | 1 | Write strobe for the frame-15 bit |
| cfg_auto_err_en | input | 1 | Enable automatic error reporting |
| cfg_loss_zero_en | input | 1 | Force zeros during multiframe loss |
| cfg_timer_zero_en | input | 1 | Force zeros after timer expiry during loss |
| rx_crc_err | input | 1 | Errored submultiframe pulse |
| rx_crc_smf | input | 1 | Submultiframe of the error (0 or 1) |
| rx_mf_loss | input | 1 | Loss of CRC-4 multiframe alignment |
| rx_fa_loss | input | 1 | Loss of basic frame alignment |
| rx_timer_exp | input | 1 | Alignment-loss timer expired |
| e_stb | output | 1 | E-bit value valid |
| e_val | output | 1 | E-bit value |
| e_sel | output | 1 | 0 = frame 13, 1 = frame 15 |

## Verification
A wrong pending count shows only at the next E-bit slot of that frame. A lost zero appears as a 1 where a 0 was queued, and a count that wrapped or failed to drain gives extra zeros. So draining a known queue slot by slot shows the fault within one multiframe per queued entry. A wrong slot decode or force path shows on the strobe that follows the faulty tick, one cycle later.

// File: rtl/ebit_pkg.sv
// Shared definitions for the E-bit transmit controller.
// Assumes two E-bit slots per multiframe, indexed 0 (frame 13) and 1 (frame 15).
package ebit_pkg;
    localparam int NUM_SLOTS = 2;
    typedef enum logic {
        SLOT_E13 = 1'b0,
        SLOT_E15 = 1'b1
    } ebit_slot_e;
endpackage

// File: rtl/ebit_slot_sel.sv
// Decodes the frame tick and multiframe position into one fire pulse per E-bit slot.
// Assumes POS_A and POS_B differ.
module ebit_slot_sel #(
    parameter int POS_W = 4,
    parameter int POS_A = 13,
    parameter int POS_B = 15
) (
    input  logic                            frame_tick,
    input  logic [POS_W-1:0]                mf_pos,
    output logic [ebit_pkg::NUM_SLOTS-1:0]  fire
);
    // Match the current position against each slot position.
    always_comb begin
        fire[ebit_pkg::SLOT_E13] = frame_tick && (mf_pos == POS_W'(POS_A));
        fire[ebit_pkg::SLOT_E15] = frame_tick && (mf_pos == POS_W'(POS_B));
    end
endmodule

// File: rtl/ebit_pend_cnt.sv
// Saturating count of queued zero bits for one E-bit slot.
// Two request inputs may pulse in the same cycle. A consume pulse retires one
// entry when the count is non-zero. Requests in a consume cycle count for later slots.
module ebit_pend_cnt #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    input  logic consume,
    output logic pending
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] MAX = SUM_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] count;
    logic [SUM_W-1:0] sum;
    logic             dec;

    // Work out the next count: add the requests, subtract one retired entry, then clamp.
    always_comb begin
        dec = consume && (count != '0);
        sum = {2'b00, count} + {{(SUM_W-1){1'b0}}, req_a} + {{(SUM_W-1){1'b0}}, req_b}
              - {{(SUM_W-1){1'b0}}, dec};
        if (sum > MAX) sum = MAX;
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= sum[CNT_W-1:0];
    end

    assign pending = (count != '0);

    // R8: a full counter stays full unless an entry is retired.
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == MAX[CNT_W-1:0]) && !consume) |=> (count == MAX[CNT_W-1:0]));

    // R10: a consume with entries present and no new request lowers the count by one.
    p_cnt_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && (count != '0) && !req_a && !req_b) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/ebit_force_src.sv
// Combines the alignment-loss conditions that force both E bits to zero.
// Assumes frame-alignment loss implies multiframe-alignment loss. Either one counts as loss.
module ebit_force_src (
    input  logic en_loss,
    input  logic en_timer,
    input  logic mf_loss,
    input  logic fa_loss,
    input  logic timer_exp,
    output logic force_zero
);
    logic loss;

    // Evaluate the two force conditions. The timer is honoured only during loss.
    always_comb begin
        loss       = mf_loss || fa_loss;
        force_zero = (en_loss && loss) || (en_timer && loss && timer_exp);
    end
endmodule

// File: rtl/ebit_tx_ctrl.sv
// E-bit transmit controller for the CRC-4 multiframe.
// Produces the registered value of the frame-13 and frame-15 E bits, with a strobe.
// Assumes frame_tick pulses for one cycle at the start of each frame, with mf_pos valid
// in that cycle, and that write and error inputs are single-cycle pulses.
module ebit_tx_ctrl #(
    parameter int POS_W = 4,
    parameter int POS_A = 13,
    parameter int POS_B = 15,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [POS_W-1:0] mf_pos,
    input  logic             cfg_oneshot,
    input  logic             cfg_e13_bit,
    input  logic             cfg_e15_bit,
    input  logic             cfg_e13_wr,
    input  logic             cfg_e15_wr,
    input  logic             cfg_auto_err_en,
    input  logic             cfg_loss_zero_en,
    input  logic             cfg_timer_zero_en,
    input  logic             rx_crc_err,
    input  logic             rx_crc_smf,
    input  logic             rx_mf_loss,
    input  logic             rx_fa_loss,
    input  logic             rx_timer_exp,
    output logic             e_stb,
    output logic             e_val,
    output logic             e_sel
);
    import ebit_pkg::*;

    logic [NUM_SLOTS-1:0] fire;
    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] ctl_bit;
    logic [NUM_SLOTS-1:0] ctl_wr;
    logic [NUM_SLOTS-1:0] direct_zero;
    logic                 force_zero;
    logic                 any_fire;
    logic                 val_next;

    assign ctl_bit = {cfg_e15_bit, cfg_e13_bit};
    assign ctl_wr  = {cfg_e15_wr, cfg_e13_wr};

    ebit_slot_sel #(.POS_W(POS_W), .POS_A(POS_A), .POS_B(POS_B)) u_sel (
        .frame_tick (frame_tick),
        .mf_pos     (mf_pos),
        .fire       (fire)
    );

    ebit_force_src u_force (
        .en_loss    (cfg_loss_zero_en),
        .en_timer   (cfg_timer_zero_en),
        .mf_loss    (rx_mf_loss),
        .fa_loss    (rx_fa_loss),
        .timer_exp  (rx_timer_exp),
        .force_zero (force_zero)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic req_man;
        logic req_err;

        // Queue requests for this slot: one-shot writes of zero and reported errors.
        always_comb begin
            req_man        = cfg_oneshot && ctl_wr[s] && !ctl_bit[s];
            req_err        = cfg_auto_err_en && rx_crc_err && (rx_crc_smf == 1'(s));
            direct_zero[s] = !cfg_oneshot && !ctl_bit[s];
        end

        ebit_pend_cnt #(.CNT_W(CNT_W)) u_pend (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_a   (req_man),
            .req_b   (req_err),
            .consume (fire[s]),
            .pending (pend[s])
        );
    end

    // AND all sources for the slot that fires: any request for zero wins.
    always_comb begin
        any_fire = |fire;
        if (fire[SLOT_E15]) val_next = !(force_zero || pend[SLOT_E15] || direct_zero[SLOT_E15]);
        else                val_next = !(force_zero || pend[SLOT_E13] || direct_zero[SLOT_E13]);
    end

    // Register the strobe, the bit value and the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_stb <= 1'b0;
            e_val <= 1'b1;
            e_sel <= 1'b0;
        end else begin
            e_stb <= any_fire;
            if (any_fire) begin
                e_val <= val_next;
                e_sel <= fire[SLOT_E15];
            end
        end
    end

    // R1: a slot tick gives a strobe on the next cycle, and no other cycle does.
    p_stb_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_fire |=> e_stb);
    p_stb_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_fire |=> !e_stb);

    // R3: a queued zero in the firing slot yields a transmitted zero.
    p_pend_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire[SLOT_E13] && pend[SLOT_E13]) || (fire[SLOT_E15] && pend[SLOT_E15])) |=> !e_val);

    // R5: enabled loss forcing yields a transmitted zero.
    p_loss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fire && cfg_loss_zero_en && rx_mf_loss) |=> !e_val);

    // R9: frame-alignment loss never appears without multiframe loss.
    p_legal_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fa_loss |-> rx_mf_loss);
endmodule

// File: tb/test_ebit_tx_ctrl.sv
module test_ebit_tx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [3:0] mf_pos = '0;
    logic cfg_oneshot = 1'b0, cfg_e13_bit = 1'b1, cfg_e15_bit = 1'b1;
    logic cfg_e13_wr = 1'b0, cfg_e15_wr = 1'b0;
    logic cfg_auto_err_en = 1'b0, cfg_loss_zero_en = 1'b0, cfg_timer_zero_en = 1'b0;
    logic rx_crc_err = 1'b0, rx_crc_smf = 1'b0, rx_mf_loss = 1'b0, rx_fa_loss = 1'b0;
    logic rx_timer_exp = 1'b0;
    logic e_stb, e_val, e_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebit_tx_ctrl i_ebit_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mf_pos(mf_pos),
        .cfg_oneshot(cfg_oneshot), .cfg_e13_bit(cfg_e13_bit), .cfg_e15_bit(cfg_e15_bit),
        .cfg_e13_wr(cfg_e13_wr), .cfg_e15_wr(cfg_e15_wr),
        .cfg_auto_err_en(cfg_auto_err_en), .cfg_loss_zero_en(cfg_loss_zero_en),
        .cfg_timer_zero_en(cfg_timer_zero_en), .rx_crc_err(rx_crc_err),
        .rx_crc_smf(rx_crc_smf), .rx_mf_loss(rx_mf_loss), .rx_fa_loss(rx_fa_loss),
        .rx_timer_exp(rx_timer_exp), .e_stb(e_stb), .e_val(e_val), .e_sel(e_sel)
    );

    typedef struct packed {
        logic os, d13, d15, en_err, en_loss, en_tim, mf, fa, tex;
        logic [3:0] pos;
        logic xs, xv;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd13,1'b1,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd13,1'b1,1'b0},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd15,1'b1,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd15,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5, 1'b0,1'b1},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd13,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd15,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd15,1'b1,1'b1},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,4'd13,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd13,1'b1,1'b1},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'd15,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd13,1'b1,1'b1},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd14,1'b0,1'b1}
    };
    localparam string TAG [0:NV-1] = '{"R7","R2","R2","R2","R1","R5","R5",
                                       "R6","R6","R6","R9","R3","R1"};

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge: present one frame start, return at the next falling edge.
    task automatic tick(input logic [3:0] p);
        frame_tick = 1'b1;
        mf_pos     = p;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic expect_bit(input logic [3:0] p, input logic v, input string tag);
        tick(p);
        check(e_stb === 1'b1, tag, int'(e_stb), 1);
        check(e_val === v, tag, int'(e_val), int'(v));
    endtask

    task automatic wr(input logic sel15, input logic d);
        if (sel15) begin cfg_e15_bit = d; cfg_e15_wr = 1'b1; end
        else       begin cfg_e13_bit = d; cfg_e13_wr = 1'b1; end
        @(negedge clk);
        cfg_e13_wr = 1'b0; cfg_e15_wr = 1'b0;
        cfg_e13_bit = 1'b1; cfg_e15_bit = 1'b1;
    endtask

    task automatic err(input logic smf);
        rx_crc_err = 1'b1; rx_crc_smf = smf;
        @(negedge clk);
        rx_crc_err = 1'b0;
    endtask

    task automatic quiet();
        cfg_oneshot = 0; cfg_e13_bit = 1; cfg_e15_bit = 1; cfg_auto_err_en = 0;
        cfg_loss_zero_en = 0; cfg_timer_zero_en = 0; rx_mf_loss = 0; rx_fa_loss = 0;
        rx_timer_exp = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R7: reset state.
        repeat (3) @(negedge clk);
        check(e_stb === 1'b0, "R7", int'(e_stb), 0);
        check(e_val === 1'b1, "R7", int'(e_val), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Level-driven vectors from the table.
        for (int i = 0; i < NV; i++) begin
            cfg_oneshot = TBL[i].os; cfg_e13_bit = TBL[i].d13; cfg_e15_bit = TBL[i].d15;
            cfg_auto_err_en = TBL[i].en_err; cfg_loss_zero_en = TBL[i].en_loss;
            cfg_timer_zero_en = TBL[i].en_tim; rx_mf_loss = TBL[i].mf;
            rx_fa_loss = TBL[i].fa; rx_timer_exp = TBL[i].tex;
            tick(TBL[i].pos);
            check(e_stb === TBL[i].xs, TAG[i], int'(e_stb), int'(TBL[i].xs));
            if (TBL[i].xs) begin
                check(e_val === TBL[i].xv, TAG[i], int'(e_val), int'(TBL[i].xv));
                // R1: slot index follows the position.
                check(e_sel === (TBL[i].pos == 4'd15), "R1", int'(e_sel),
                      int'(TBL[i].pos == 4'd15));
            end
            @(negedge clk);
        end
        quiet();

        // R3: one-shot writes of zero queue one zero each; writes of one are ignored.
        cfg_oneshot = 1'b1;
        wr(1'b0, 1'b0); wr(1'b0, 1'b0); wr(1'b1, 1'b1);
        expect_bit(4'd13, 1'b0, "R3");
        expect_bit(4'd15, 1'b1, "R3");
        expect_bit(4'd13, 1'b0, "R3");
        expect_bit(4'd13, 1'b1, "R3");
        quiet();

        // R4: error pulses are ignored when disabled, then routed by submultiframe.
        err(1'b0);
        expect_bit(4'd13, 1'b1, "R4");
        cfg_auto_err_en = 1'b1;
        err(1'b1);
        expect_bit(4'd13, 1'b1, "R4");
        expect_bit(4'd15, 1'b0, "R4");
        expect_bit(4'd15, 1'b1, "R4");
        err(1'b0);
        expect_bit(4'd13, 1'b0, "R4");
        quiet();

        // R8: the queue saturates at seven entries.
        cfg_oneshot = 1'b1;
        for (int k = 0; k < 9; k++) wr(1'b0, 1'b0);
        for (int k = 0; k < 7; k++) expect_bit(4'd13, 1'b0, "R8");
        expect_bit(4'd13, 1'b1, "R8");

        // R8: a write in the slot's own tick cycle is served at the next slot.
        cfg_e13_bit = 1'b0; cfg_e13_wr = 1'b1;
        tick(4'd13);
        cfg_e13_wr = 1'b0; cfg_e13_bit = 1'b1;
        check(e_val === 1'b1, "R8", int'(e_val), 1);
        expect_bit(4'd13, 1'b0, "R8");

        // R10: a forced zero also retires a queued zero.
        wr(1'b1, 1'b0); wr(1'b1, 1'b0);
        cfg_loss_zero_en = 1'b1; rx_mf_loss = 1'b1;
        expect_bit(4'd15, 1'b0, "R10");
        rx_mf_loss = 1'b0;
        expect_bit(4'd15, 1'b0, "R10");
        expect_bit(4'd15, 1'b1, "R10");
        quiet();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule